// File: doc/BRIEF.md
# Median-Gradient Preprocessing Stage

This block cleans up and binarises a grayscale image as it streams between two memory ports. Image data comes in as 32-bit words, four 8-bit pixels per word, in raster order from the top-left to the bottom-right pixel. The block splits each word into single pixels and processes one pixel per clock. It applies a 3x3 median filter to remove impulse noise. A 3x3 morphological gradient on the filtered image then marks intensity changes. A compare against a run-time threshold turns the result into a binary edge map, which leaves the block packed four pixels to a 32-bit word.

Row history is held on chip, so each input pixel is read only once. Pixels outside the image take the value of the nearest pixel on the border, so the output image has the same size as the input. A one-cycle start-of-frame pulse is given before each frame. Once the last input word of a frame has been taken, the block pushes its pipeline empty by itself. If the output side stops taking words, the whole pipeline stops, and no pixel is lost or repeated. `IMG_W * IMG_H` must be a multiple of four. `threshold` is held steady for the length of a frame.

Top module: `medGradStage`

## Requirements
- R1: Each input word supplies four pixels over four consecutive pipeline steps, bits [31:24] first. When `iValid` and `oReady` stay high, input words are taken back to back, one pixel per clock. A whole frame then completes within `IMG_W*IMG_H + 2*(IMG_W+1) + 20` cycles of its first word.
- R2: The filtered value at each position is the median of the 3x3 neighbourhood. A neighbour outside the image takes the value at the nearest row and column index that lies inside it.
- R3: The gradient at each position is the maximum minus the minimum of the nine filtered values around it, with the same border rule as R2.
- R4: An output pixel is 8'hFF when the gradient is greater than or equal to `threshold`, and 8'h00 otherwise. Every byte of an output word is 8'h00 or 8'hFF.
- R5: Each output word carries four consecutive result pixels, the first in bits [31:24] and the last in bits [7:0]. Each frame yields exactly `IMG_W*IMG_H/4` words, in raster order.
- R6: While `oValid` is high and `oReady` is low, `oValid` stays high, `oData` holds steady and `iReady` is low.
- R7: One cycle after `frameStart`, `oValid` is low and `iReady` is high. The frame that follows is processed as if it were the first since reset.
- R8: After a frame's last input word has been taken, `iReady` stays low and no further output word appears until the next `frameStart`.
- R9: Out of reset, `oValid` is low, `oData` is zero and `iReady` is high.
- R10: With `threshold` at 0, every output pixel is 8'hFF. With `threshold` at 255, only a gradient of exactly 255 gives 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameStart | input | 1 | One-cycle pulse before each frame; clears all frame state |
| threshold | input | 8 | Binarisation level, held steady for the length of a frame |
| iValid | input | 1 | Input word valid |
| iData | input | 32 | Four pixels; the first pixel is in bits [31:24] |
| iReady | output | 1 | Block takes the input word this cycle |
| oValid | output | 1 | Output word valid |
| oData | output | 32 | Four binary pixels; the first pixel is in bits [31:24] |
| oReady | input | 1 | Downstream takes the output word this cycle |

## Verification
The bench builds the block with `IMG_W = 8` and `IMG_H = 5`. At this size the clamped first and last rows and columns cover most of the image, so the corners and the rows past the bottom edge are hit in every frame, and the flush after the last word stays short. The frames cover impulse noise, steps placed exactly at the threshold and one above it, a ramp, a flat image at threshold 0, and random images at threshold 255. Random gaps on the input and random back-pressure on the output move the stall points across every pipeline stage.

// File: rtl/mgPkg.sv
package mgPkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic clear;      // start of frame: drop all frame state
    logic run;        // whole pipeline advances this cycle
    logic load;       // capture a new input word
    logic step;       // push one pixel into the first window stage
    logic pad;        // the pushed pixel is a flush filler
    logic packShift;  // shift one result into the output word
  } ctlStrobes_t;

  typedef logic [8:0][7:0] win9_t;

  // Compare-exchange pairs of a 19-element median-of-nine network
  localparam int SORT_A [19] = '{1, 4, 7, 0, 3, 6, 1, 4, 7, 0, 5, 4, 3, 1, 2, 4, 4, 6, 4};
  localparam int SORT_B [19] = '{2, 5, 8, 1, 4, 7, 2, 5, 8, 3, 8, 7, 6, 4, 5, 7, 2, 4, 2};

  function automatic win9_t sortRange(input win9_t v, input int first, input int last);
    win9_t r;
    logic [7:0] t;
    r = v;
    for (int i = first; i <= last; i++) begin
      if (r[4'(SORT_A[i])] > r[4'(SORT_B[i])]) begin
        t = r[4'(SORT_A[i])];
        r[4'(SORT_A[i])] = r[4'(SORT_B[i])];
        r[4'(SORT_B[i])] = t;
      end
    end
    return r;
  endfunction

  function automatic logic [7:0] max3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    logic [7:0] m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic logic [7:0] min3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    logic [7:0] m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

endpackage

// File: rtl/mgControl.sv
module mgControl
  import mgPkg::*;
#(
  parameter int IMG_W = 32,
  parameter int IMG_H = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  input  logic        iValid,
  input  logic        oReady,
  input  logic        resValid,
  output logic        iReady,
  output logic        oValid,
  output ctlStrobes_t ctl
);
  localparam int NPIX   = IMG_W * IMG_H;
  localparam int NWORDS = NPIX / 4;
  localparam int NPAD   = 2 * (IMG_W + 1);
  localparam int WCW    = $clog2(NWORDS + 1);
  localparam int PCW    = $clog2(NPAD + 1);

  logic [WCW-1:0] wordCnt;
  logic [2:0]     bytesLeft;
  logic [PCW-1:0] padCnt;
  logic [1:0]     packCnt;
  logic           oValidQ;

  logic run, allIn, canLoad, doLoad, pixStep, padStep;

  always_comb begin
    run     = !(oValidQ && !oReady);
    allIn   = (wordCnt == WCW'(NWORDS));
    canLoad = run && !frameStart && !allIn && (bytesLeft <= 3'd1);
    doLoad  = canLoad && iValid;
    pixStep = run && !frameStart && (bytesLeft != 3'd0);
    padStep = run && !frameStart && allIn && (bytesLeft == 3'd0) && (padCnt != PCW'(NPAD));

    ctl.clear     = frameStart;
    ctl.run       = run;
    ctl.load      = doLoad;
    ctl.step      = pixStep || padStep;
    ctl.pad       = padStep;
    ctl.packShift = run && !frameStart && resValid;

    iReady = canLoad;
    oValid = oValidQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordCnt   <= '0;
      bytesLeft <= '0;
      padCnt    <= '0;
      packCnt   <= '0;
      oValidQ   <= 1'b0;
    end else if (frameStart) begin
      wordCnt   <= '0;
      bytesLeft <= '0;
      padCnt    <= '0;
      packCnt   <= '0;
      oValidQ   <= 1'b0;
    end else if (run) begin
      if (doLoad)                  bytesLeft <= 3'd4;
      else if (bytesLeft != 3'd0)  bytesLeft <= bytesLeft - 3'd1;
      if (doLoad)  wordCnt <= wordCnt + WCW'(1);
      if (padStep) padCnt  <= padCnt + PCW'(1);
      if (resValid) packCnt <= packCnt + 2'd1;
      oValidQ <= resValid && (packCnt == 2'd3);
    end
  end

endmodule

// File: rtl/mgWindowOp.sv
module mgWindowOp
  import mgPkg::*;
#(
  parameter int OP = 0   // 0: median of nine, 1: max minus min
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clear,
  input  logic       run,
  input  logic       inValid,
  input  win9_t      win,
  output logic       outValid,
  output logic [7:0] outPix
);

  if (OP == 0) begin : gMedian
    win9_t      m0, m1, m2;
    logic [2:0] v;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        m0 <= '0; m1 <= '0; m2 <= '0; v <= '0;
      end else if (clear) begin
        v <= '0;
      end else if (run) begin
        m0 <= sortRange(win, 0, 8);
        m1 <= sortRange(m0, 9, 14);
        m2 <= sortRange(m1, 15, 18);
        v  <= {v[1:0], inValid};
      end
    end
    assign outValid = v[2];
    assign outPix   = m2[4];
  end else begin : gGradient
    logic [2:0][7:0] rowMax, rowMin;
    logic [7:0]      diff;
    logic [1:0]      v;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rowMax <= '0; rowMin <= '0; diff <= '0; v <= '0;
      end else if (clear) begin
        v <= '0;
      end else if (run) begin
        for (int g = 0; g < 3; g++) begin
          rowMax[g] <= max3(win[g*3], win[g*3+1], win[g*3+2]);
          rowMin[g] <= min3(win[g*3], win[g*3+1], win[g*3+2]);
        end
        diff <= max3(rowMax[0], rowMax[1], rowMax[2]) - min3(rowMin[0], rowMin[1], rowMin[2]);
        v    <= {v[0], inValid};
      end
    end
    assign outValid = v[1];
    assign outPix   = diff;
  end

endmodule

// File: rtl/mgWindowStage.sv
module mgWindowStage
  import mgPkg::*;
#(
  parameter int IMG_W = 32,
  parameter int IMG_H = 24,
  parameter int OP    = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clear,
  input  logic       run,
  input  logic       inValid,
  input  logic [7:0] inPix,
  output logic       outValid,
  output logic [7:0] outPix
);
  localparam int NPIX = IMG_W * IMG_H;
  localparam int TAPS = 2 * IMG_W + 3;
  localparam int LEAD = IMG_W + 1;
  localparam int KMAX = NPIX + 2 * IMG_W + 2;
  localparam int KW   = $clog2(KMAX + 1);
  localparam int CW   = $clog2(IMG_W);
  localparam int RW   = $clog2(IMG_H + 2) + 1;

  logic [7:0]    dl [TAPS];
  logic [KW-1:0] k;
  logic [CW-1:0] ocCol, cCol;
  logic [RW-1:0] ocRow, cRow;
  logic          winValid, emit;
  logic          topEdge, botEdge, lftEdge, rgtEdge;
  win9_t         win;

  assign emit = inValid && (k >= KW'(LEAD));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TAPS; i++) dl[i] <= '0;
      k <= '0; ocCol <= '0; ocRow <= '0; cCol <= '0; cRow <= '0; winValid <= 1'b0;
    end else if (clear) begin
      for (int i = 0; i < TAPS; i++) dl[i] <= '0;
      k <= '0; ocCol <= '0; ocRow <= '0; cCol <= '0; cRow <= '0; winValid <= 1'b0;
    end else if (run) begin
      if (inValid) begin
        dl[0] <= inPix;
        for (int i = 1; i < TAPS; i++) dl[i] <= dl[i-1];
        if (k < KW'(KMAX)) k <= k + KW'(1);
      end
      winValid <= emit;
      if (emit) begin
        cCol <= ocCol;
        cRow <= ocRow;
        if (ocCol == CW'(IMG_W - 1)) begin
          ocCol <= '0;
          ocRow <= ocRow + RW'(1);
        end else begin
          ocCol <= ocCol + CW'(1);
        end
      end
    end
  end

  assign topEdge = (cRow == '0);
  assign botEdge = (cRow == RW'(IMG_H - 1));
  assign lftEdge = (cCol == '0);
  assign rgtEdge = (cCol == CW'(IMG_W - 1));

  // Neighbour (gr,gc) sits (2-gr)*IMG_W + (2-gc) taps behind the newest pixel
  for (genvar gr = 0; gr < 3; gr++) begin : gRow
    for (genvar gc = 0; gc < 3; gc++) begin : gCol
      localparam int IDX_N  = (2 - gr) * IMG_W + (2 - gc);
      localparam int IDX_R  = IMG_W + (2 - gc);
      localparam int IDX_C  = (2 - gr) * IMG_W + 1;
      localparam int IDX_RC = IMG_W + 1;
      logic clR, clC;
      assign clR = (gr == 0) ? topEdge : ((gr == 2) ? botEdge : 1'b0);
      assign clC = (gc == 0) ? lftEdge : ((gc == 2) ? rgtEdge : 1'b0);
      assign win[gr*3+gc] = clR ? (clC ? dl[IDX_RC] : dl[IDX_R])
                                : (clC ? dl[IDX_C]  : dl[IDX_N]);
    end
  end

  mgWindowOp #(.OP(OP)) op_i (
    .clk(clk), .rstN(rstN), .clear(clear), .run(run),
    .inValid(winValid), .win(win),
    .outValid(outValid), .outPix(outPix)
  );

endmodule

// File: rtl/mgDatapath.sv
module mgDatapath
  import mgPkg::*;
#(
  parameter int IMG_W = 32,
  parameter int IMG_H = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t ctl,
  input  logic [31:0] iData,
  input  logic [7:0]  threshold,
  output logic        resValid,
  output logic [31:0] oData
);
  logic [31:0] wordReg;
  logic [7:0]  pixIn, medPix, gradPix, resPix;
  logic        medValid, gradValid;
  logic [31:0] packReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          wordReg <= '0;
    else if (ctl.clear) wordReg <= '0;
    else if (ctl.run) begin
      if (ctl.load)      wordReg <= iData;
      else if (ctl.step) wordReg <= {wordReg[23:0], 8'h00};
    end
  end

  assign pixIn = ctl.pad ? 8'h00 : wordReg[31:24];

  mgWindowStage #(.IMG_W(IMG_W), .IMG_H(IMG_H), .OP(0)) medStage_i (
    .clk(clk), .rstN(rstN), .clear(ctl.clear), .run(ctl.run),
    .inValid(ctl.step), .inPix(pixIn),
    .outValid(medValid), .outPix(medPix)
  );

  mgWindowStage #(.IMG_W(IMG_W), .IMG_H(IMG_H), .OP(1)) gradStage_i (
    .clk(clk), .rstN(rstN), .clear(ctl.clear), .run(ctl.run),
    .inValid(medValid), .inPix(medPix),
    .outValid(gradValid), .outPix(gradPix)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0; resPix <= '0;
    end else if (ctl.clear) begin
      resValid <= 1'b0;
    end else if (ctl.run) begin
      resValid <= gradValid;
      resPix   <= (gradPix >= threshold) ? 8'hFF : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              packReg <= '0;
    else if (ctl.clear)     packReg <= '0;
    else if (ctl.packShift) packReg <= {packReg[23:0], resPix};
  end

  assign oData = packReg;

endmodule

// File: rtl/medGradStage.sv
module medGradStage
  import mgPkg::*;
#(
  parameter int IMG_W = 32,
  parameter int IMG_H = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  input  logic [7:0]  threshold,
  input  logic        iValid,
  input  logic [31:0] iData,
  output logic        iReady,
  output logic        oValid,
  output logic [31:0] oData,
  input  logic        oReady
);
  ctlStrobes_t ctl;
  logic        resValid;

  mgControl #(.IMG_W(IMG_W), .IMG_H(IMG_H)) ctrl_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .iValid(iValid), .oReady(oReady), .resValid(resValid),
    .iReady(iReady), .oValid(oValid), .ctl(ctl)
  );

  mgDatapath #(.IMG_W(IMG_W), .IMG_H(IMG_H)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .iData(iData), .threshold(threshold),
    .resValid(resValid), .oData(oData)
  );

endmodule

// File: rtl/mgChecker.sv
module mgChecker (
  input logic        clk,
  input logic        rstN,
  input logic        frameStart,
  input logic        iReady,
  input logic        oValid,
  input logic [31:0] oData,
  input logic        oReady
);

  // R6: a refused word stays offered and unchanged
  a_r6_hold_word: assert property (@(posedge clk) disable iff (!rstN)
    oValid && !oReady && !frameStart |=> oValid && $stable(oData));

  // R6: no input is taken while the output is refused
  a_r6_no_accept: assert property (@(posedge clk) disable iff (!rstN)
    oValid && !oReady |-> !iReady);

  // R7: start of frame withdraws any pending word
  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !oValid);

  // R4: output bytes are binary
  a_r4_binary: assert property (@(posedge clk) disable iff (!rstN)
    oValid |-> ((oData[31:24] == 8'h00) || (oData[31:24] == 8'hFF)) &&
               ((oData[23:16] == 8'h00) || (oData[23:16] == 8'hFF)) &&
               ((oData[15:8]  == 8'h00) || (oData[15:8]  == 8'hFF)) &&
               ((oData[7:0]   == 8'h00) || (oData[7:0]   == 8'hFF)));

endmodule

bind medGradStage mgChecker chk_i (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .iReady(iReady),
  .oValid(oValid), .oData(oData), .oReady(oReady)
);

// File: tb/medGradStage_tb_top.sv
`timescale 1ns/1ps
module medGradStage_tb_top;
  localparam int W  = 8;
  localparam int H  = 5;
  localparam int N  = W * H;
  localparam int NW = N / 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0;
  logic [7:0]  threshold = 8'd0;
  logic        iValid = 1'b0;
  logic [31:0] iData = '0;
  logic        iReady;
  logic        oValid;
  logic [31:0] oData;
  logic        oReady = 1'b0;

  always #2.5 clk = ~clk;

  medGradStage #(.IMG_W(W), .IMG_H(H)) dut_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .threshold(threshold),
    .iValid(iValid), .iData(iData), .iReady(iReady),
    .oValid(oValid), .oData(oData), .oReady(oReady)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int cycles = 0;

  logic [7:0]  img [N];
  logic [7:0]  med [N];
  logic [7:0]  res [N];
  logic [31:0] inW [NW];
  logic [31:0] expW [NW];
  logic [31:0] gotW [NW];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int clampI(input int v, input int hi);
    return (v < 0) ? 0 : ((v > hi) ? hi : v);
  endfunction

  function automatic logic [7:0] medianAt(input int r, input int c);
    logic [7:0] v [9];
    logic [7:0] t;
    int n = 0;
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++) begin
        v[n] = img[clampI(r + dr, H - 1) * W + clampI(c + dc, W - 1)];
        n++;
      end
    for (int i = 0; i < 9; i++)
      for (int j = 0; j < 8 - i; j++)
        if (v[j] > v[j+1]) begin t = v[j]; v[j] = v[j+1]; v[j+1] = t; end
    return v[4];
  endfunction

  function automatic logic [7:0] gradAt(input int r, input int c);
    logic [7:0] mx = 8'h00;
    logic [7:0] mn = 8'hFF;
    logic [7:0] x;
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++) begin
        x = med[clampI(r + dr, H - 1) * W + clampI(c + dc, W - 1)];
        if (x > mx) mx = x;
        if (x < mn) mn = x;
      end
    return mx - mn;
  endfunction

  // mode 0 random, 1 flat with impulses, 2 vertical step 10/60, 3 flat, 4 ramp
  task automatic buildFrame(input int mode, input logic [7:0] th);
    for (int i = 0; i < N; i++) begin
      int r = i / W;
      int c = i % W;
      case (mode)
        0: img[i] = 8'($urandom);
        1: img[i] = ((r % 2 == 1) && (c % 3 == 1)) ? 8'd255 : 8'd100;
        2: img[i] = (c < W / 2) ? 8'd10 : 8'd60;
        3: img[i] = 8'd77;
        default: img[i] = 8'(r * 40 + c * 3);
      endcase
    end
    for (int i = 0; i < N; i++) med[i] = medianAt(i / W, i % W);
    for (int i = 0; i < N; i++) res[i] = (gradAt(i / W, i % W) >= th) ? 8'hFF : 8'h00;
    for (int j = 0; j < NW; j++) begin
      inW[j]  = {img[4*j], img[4*j+1], img[4*j+2], img[4*j+3]};
      expW[j] = {res[4*j], res[4*j+1], res[4*j+2], res[4*j+3]};
    end
  endtask

  task automatic runFrame(input int mode, input int pIn, input int pOut,
                          input logic [7:0] th, input string tag, output int spent);
    int  idx = 0;
    int  got = 0;
    int  cyc = 0;
    bit  stallBad = 0;
    bit  extra = 0;
    buildFrame(mode, th);
    threshold = th;
    @(negedge clk);
    frameStart = 1'b1; iValid = 1'b0; oReady = 1'b0;
    @(negedge clk);
    frameStart = 1'b0;
    #1;
    check(iReady && !oValid, "R7 after frameStart", {30'd0, iReady, oValid}, 32'h2);
    while (got < NW && cyc < 6000) begin
      iValid = (idx < NW) && (($urandom % 100) < pIn);
      iData  = (idx < NW) ? inW[idx] : $urandom;
      oReady = (($urandom % 100) < pOut);
      #1;
      if (oValid && !oReady && iReady) stallBad = 1;
      if (iValid && iReady) idx++;
      if (oValid && oReady) begin gotW[got] = oData; got++; end
      @(negedge clk);
      cyc++;
    end
    spent = cyc;
    check(!stallBad, "R6 iReady low while output refused", {31'd0, stallBad}, 32'd0);
    check(got == NW, "R5 word count per frame", got, NW);
    for (int t = 0; t < 3 * W + 40; t++) begin
      iValid = 1'b1; iData = $urandom; oReady = 1'b1;
      #1;
      if (oValid || iReady) extra = 1;
      @(negedge clk);
    end
    iValid = 1'b0;
    check(!extra, "R8 nothing after frame end", {31'd0, extra}, 32'd0);
    for (int j = 0; j < got; j++)
      check(gotW[j] === expW[j], tag, gotW[j], expW[j]);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int spent;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R9: reset state
    check(!oValid && iReady && (oData == 32'd0), "R9 reset state",
          {oData[29:0], iReady, oValid}, 32'h2);

    // R1: full rate, MSB-first unpacking and throughput bound
    runFrame(0, 100, 100, 8'd60, "R1 data", spent);
    check(spent <= N + 2 * (W + 1) + 20, "R1 full-rate cycles", spent, N + 2 * (W + 1) + 20);

    runFrame(1, 80, 70, 8'd1,   "R2 impulse removal", spent);
    runFrame(2, 60, 50, 8'd50,  "R4 gradient equal threshold", spent);
    runFrame(2, 90, 90, 8'd51,  "R4 gradient one below threshold", spent);
    runFrame(4, 70, 40, 8'd50,  "R3 ramp gradient", spent);
    runFrame(3, 75, 75, 8'd0,   "R10 threshold zero", spent);
    runFrame(0, 75, 75, 8'd255, "R10 threshold max", spent);
    for (int f = 0; f < 8; f++)
      runFrame(0, 30 + 10 * f, 90 - 8 * f, 8'($urandom % 200), "R5 random frame", spent);
    runFrame(1, 100, 30, 8'd120, "R6 heavy back-pressure", spent);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule